// File: doc/BRIEF.md
# Endian-Ordered Bus Width Splitter

This block sits between a 64-bit internal memory request path and an external data bus. A mode bit sets the external bus to its full 64-bit width or to 32 bits. In full-width mode each accepted request becomes one external beat. In 32-bit mode each request becomes exactly two back-to-back beats on the low lanes, and an endianness input picks which half of the 64-bit word goes first. The block steers write data and byte masks into the beats. On reads it places the two received halves back into the 64-bit response word.

Requests enter through a valid/ready handshake and are accepted only when the sequencer is idle. The mode and endianness inputs are captured when a request is accepted. The external side uses a one-cycle beat strobe per beat. Read data is sampled on the clock edge that ends each read beat. A one-cycle response pulse follows the final beat of every transfer. For reads it carries the assembled 64-bit word. Command timing, address handling and refresh belong to other blocks.

Top module: `bus_width_splitter`

## Requirements
- R1: With `cfg_narrow`=0 at acceptance, the transfer is a single beat. Data on `ext_dq_out` is the full `req_wdata`, and `ext_dm` is the bitwise inverse of `req_be` (a mask bit of 1 means the byte is masked).
- R2: With `cfg_narrow`=1 at acceptance, exactly two consecutive beats are issued for every byte-enable pattern, including patterns that cover one half only and the pattern 0.
- R3: In 32-bit mode with `cfg_big_endian`=1, the first beat carries internal bits [63:32] on lanes [31:0] and the second beat carries bits [31:0]. With `cfg_big_endian`=0 the order is reversed.
- R4: During each 32-bit beat, `ext_dm[7:4]` is 4'hF. `ext_dm[3:0]` is the inverse of the byte enables of the half being transferred (`req_be[7:4]` for bits [63:32], `req_be[3:0]` for bits [31:0]).
- R5: On write beats both `ext_dq_oe_lo` and `ext_dq_oe_hi` are 1. In 32-bit mode the upper lanes [63:32] carry the fill value, which is all zeros by default. On read beats both enables are 0.
- R6: On a 32-bit read, the lane [31:0] data of the beat that carried the upper half is placed in `rsp_rdata[63:32]`, and the other beat's data is placed in `rsp_rdata[31:0]`. A 64-bit read returns `ext_dq_in` unchanged.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle after the final beat. For reads, `rsp_rdata` holds the assembled word in that cycle.
- R8: `req_ready` is 1 when no beat is in progress and 0 during every beat.
- R9: Changes on `cfg_narrow` and `cfg_big_endian` after acceptance have no effect on the beats of the accepted transfer.
- R10: Synchronous active-high reset returns the block to idle: `req_ready`=1, `ext_beat`=0, both output enables 0, `ext_dm` all ones and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | 1 selects the 32-bit external bus |
| cfg_big_endian | input | 1 | 1 sends the upper half first in 32-bit mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, 1 = byte used |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Assembled read data |
| ext_beat | output | 1 | High for each external beat |
| ext_we | output | 1 | Beat direction, 1 = write |
| ext_dq_out | output | 64 | Outgoing data lanes |
| ext_dq_oe_lo | output | 1 | Output enable of lanes [31:0] |
| ext_dq_oe_hi | output | 1 | Output enable of lanes [63:32] |
| ext_dm | output | 8 | Byte mask lanes, 1 = masked |
| ext_dq_in | input | 64 | Incoming data lanes |

## Verification
A sequencer stuck in or skipping a state shows up at once at the ports. `ext_beat` then lasts one cycle too long or too short, and `req_ready` falls or rises on the wrong cycle, both within two cycles of acceptance. A wrong captured endianness or half selector makes beat data and `ext_dm[3:0]` come from the wrong half on the very first beat. On reads it swaps the two halves of `rsp_rdata` one cycle after the last beat. The bench sweeps width, endianness, direction, byte-enable patterns and data patterns, and it flips the configuration inputs during every transfer.

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic [1:0] {
      BWS_IDLE   = 2'd0,
      BWS_FIRST  = 2'd1,
      BWS_SECOND = 2'd2
   } bws_state_e;
endpackage

// File: rtl/bws_seq.sv
module bws_seq
   import bws_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic req_write,
   input  logic cfg_narrow,
   input  logic cfg_big_endian,
   output logic ready,
   output logic accept,
   output logic active,
   output logic last,
   output logic hi_half,
   output logic narrow_q,
   output logic we_q
);
   bws_state_e state_q;
   logic       big_q;

   assign ready   = (state_q == BWS_IDLE);
   assign accept  = ready && req_valid;
   assign active  = (state_q != BWS_IDLE);
   assign last    = (state_q == BWS_SECOND) || ((state_q == BWS_FIRST) && !narrow_q);
   assign hi_half = (state_q == BWS_FIRST) ? big_q : !big_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= BWS_IDLE;
         narrow_q <= 1'b0;
         big_q    <= 1'b0;
         we_q     <= 1'b0;
      end else begin
         unique case (state_q)
            BWS_IDLE: if (accept) begin
               state_q  <= BWS_FIRST;
               narrow_q <= cfg_narrow;
               big_q    <= cfg_big_endian;
               we_q     <= req_write;
            end
            BWS_FIRST:  state_q <= narrow_q ? BWS_SECOND : BWS_IDLE;
            BWS_SECOND: state_q <= BWS_IDLE;
            default:    state_q <= BWS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bws_lane_steer.sv
module bws_lane_steer #(
   parameter int DATA_W     = 64,
   parameter int UPPER_FILL = 0,
   localparam int HALF_W    = DATA_W / 2,
   localparam int BE_W      = DATA_W / 8,
   localparam int HBE_W     = BE_W / 2
) (
   input  logic              active,
   input  logic              narrow,
   input  logic              hi_half,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   be,
   output logic [DATA_W-1:0] dq_out,
   output logic [BE_W-1:0]   dm,
   output logic              oe_lo,
   output logic              oe_hi
);
   logic [HALF_W-1:0] half_data;
   logic [HBE_W-1:0]  half_be;
   logic [HALF_W-1:0] fill;

   assign half_data = hi_half ? wdata[DATA_W-1:HALF_W] : wdata[HALF_W-1:0];
   assign half_be   = hi_half ? be[BE_W-1:HBE_W] : be[HBE_W-1:0];

   generate
      if (UPPER_FILL == 0) begin : g_fill_zero
         assign fill = '0;
      end else begin : g_fill_mirror
         assign fill = half_data;
      end
   endgenerate

   assign oe_lo  = active && we;
   assign oe_hi  = active && we;
   assign dq_out = narrow ? {fill, half_data} : wdata;

   for (genvar b = 0; b < BE_W; b++) begin : g_mask
      if (b < HBE_W) begin : g_low
         assign dm[b] = !active || (narrow ? !half_be[b] : !be[b]);
      end else begin : g_high
         assign dm[b] = !active || narrow || !be[b];
      end
   end
endmodule

// File: rtl/bws_rd_assemble.sv
module bws_rd_assemble #(
   parameter int DATA_W  = 64,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              last,
   input  logic              narrow,
   input  logic              hi_half,
   input  logic              we,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= active && last;
         if (active && !we) begin
            if (!narrow)
               rsp_rdata <= dq_in;
            else if (hi_half)
               rsp_rdata[DATA_W-1:HALF_W] <= dq_in[HALF_W-1:0];
            else
               rsp_rdata[HALF_W-1:0] <= dq_in[HALF_W-1:0];
         end
      end
   end
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
   parameter int DATA_W     = 64,
   parameter int UPPER_FILL = 0,
   localparam int BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_narrow,
   input  logic              cfg_big_endian,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ext_beat,
   output logic              ext_we,
   output logic [DATA_W-1:0] ext_dq_out,
   output logic              ext_dq_oe_lo,
   output logic              ext_dq_oe_hi,
   output logic [BE_W-1:0]   ext_dm,
   input  logic [DATA_W-1:0] ext_dq_in
);
   generate
      if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 16");
      end
      if (UPPER_FILL < 0 || UPPER_FILL > 1) begin : g_bad_fill
         $error("UPPER_FILL must be 0 or 1");
      end
   endgenerate

   logic              accept, active, last, hi_half, narrow_q, we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [BE_W-1:0]   be_q;

   bws_seq i_seq (
      .clk            (clk),
      .rst            (rst),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .cfg_narrow     (cfg_narrow),
      .cfg_big_endian (cfg_big_endian),
      .ready          (req_ready),
      .accept         (accept),
      .active         (active),
      .last           (last),
      .hi_half        (hi_half),
      .narrow_q       (narrow_q),
      .we_q           (we_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wdata_q <= '0;
         be_q    <= '0;
      end else if (accept) begin
         wdata_q <= req_wdata;
         be_q    <= req_be;
      end
   end

   bws_lane_steer #(.DATA_W(DATA_W), .UPPER_FILL(UPPER_FILL)) i_steer (
      .active  (active),
      .narrow  (narrow_q),
      .hi_half (hi_half),
      .we      (we_q),
      .wdata   (wdata_q),
      .be      (be_q),
      .dq_out  (ext_dq_out),
      .dm      (ext_dm),
      .oe_lo   (ext_dq_oe_lo),
      .oe_hi   (ext_dq_oe_hi)
   );

   bws_rd_assemble #(.DATA_W(DATA_W)) i_rd (
      .clk       (clk),
      .rst       (rst),
      .active    (active),
      .last      (last),
      .narrow    (narrow_q),
      .hi_half   (hi_half),
      .we        (we_q),
      .dq_in     (ext_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign ext_beat = active;
   assign ext_we   = active && we_q;
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
   parameter int DATA_W  = 64,
   localparam int BE_W   = DATA_W / 8,
   localparam int HBE_W  = BE_W / 2
) (
   input logic            clk,
   input logic            rst,
   input logic            req_valid,
   input logic            req_ready,
   input logic            cfg_narrow,
   input logic            ext_beat,
   input logic            ext_we,
   input logic [BE_W-1:0] ext_dm,
   input logic            ext_dq_oe_lo,
   input logic            ext_dq_oe_hi,
   input logic            rsp_valid
);
   // R1
   wide_one_beat_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && !cfg_narrow) |=> ext_beat ##1 !ext_beat);

   // R2
   narrow_two_beats_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && cfg_narrow) |=> ext_beat ##1 ext_beat ##1 !ext_beat);

   // R4
   upper_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && cfg_narrow) |=>
         (ext_dm[BE_W-1:HBE_W] == '1) ##1 (ext_dm[BE_W-1:HBE_W] == '1));

   // R5
   read_hiz_chk: assert property (@(posedge clk) disable iff (rst)
      (ext_beat && !ext_we) |-> (!ext_dq_oe_lo && !ext_dq_oe_hi));

   // R7
   rsp_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> ($past(ext_beat) && !ext_beat));

   // R8
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
      ext_beat |-> !req_ready);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !ext_beat |-> (ext_dm == '1 && !ext_dq_oe_lo && !ext_dq_oe_hi && req_ready));
endmodule

bind bus_width_splitter bws_checker #(.DATA_W(DATA_W)) i_bws_checker (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .cfg_narrow   (cfg_narrow),
   .ext_beat     (ext_beat),
   .ext_we       (ext_we),
   .ext_dm       (ext_dm),
   .ext_dq_oe_lo (ext_dq_oe_lo),
   .ext_dq_oe_hi (ext_dq_oe_hi),
   .rsp_valid    (rsp_valid)
);

// File: tb/test_bus_width_splitter.sv
module test_bus_width_splitter;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_narrow, cfg_big_endian;
   logic        req_valid, req_ready, req_write;
   logic [63:0] req_wdata;
   logic [7:0]  req_be;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        ext_beat, ext_we, ext_dq_oe_lo, ext_dq_oe_hi;
   logic [63:0] ext_dq_out, ext_dq_in;
   logic [7:0]  ext_dm;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bus_width_splitter i_bus_width_splitter (
      .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_big_endian(cfg_big_endian),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ext_beat(ext_beat), .ext_we(ext_we), .ext_dq_out(ext_dq_out),
      .ext_dq_oe_lo(ext_dq_oe_lo), .ext_dq_oe_hi(ext_dq_oe_hi), .ext_dm(ext_dm),
      .ext_dq_in(ext_dq_in)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Check one beat of a transfer; hi = which internal half this beat carries.
   task automatic check_beat(input bit narrow, input bit wr, input bit hi,
                             input logic [63:0] d, input logic [7:0] be);
      logic [31:0] hd;
      logic [3:0]  hb;
      hd = hi ? d[63:32] : d[31:0];
      hb = hi ? be[7:4] : be[3:0];
      check("R8 ready low in beat", {63'd0, req_ready}, 64'd0);
      check(narrow ? "R2 beat strobe" : "R1 beat strobe", {63'd0, ext_beat}, 64'd1);
      check("R5 oe lo", {63'd0, ext_dq_oe_lo}, {63'd0, wr});
      check("R5 oe hi", {63'd0, ext_dq_oe_hi}, {63'd0, wr});
      if (narrow) begin
         check("R4 mask lanes", {56'd0, ext_dm}, {56'd0, 4'hF, ~hb});
         if (wr) check("R3 R5 narrow write lanes", ext_dq_out, {32'd0, hd});
      end else begin
         check("R1 mask lanes", {56'd0, ext_dm}, {56'd0, ~be});
         if (wr) check("R1 wide write lanes", ext_dq_out, d);
      end
   endtask

   task automatic xfer(input bit narrow, input bit big, input bit wr,
                       input logic [63:0] d, input logic [7:0] be,
                       input logic [31:0] ra, input logic [31:0] rb);
      logic [63:0] exp_rd;
      check("R8 ready in idle", {63'd0, req_ready}, 64'd1);
      cfg_narrow = narrow; cfg_big_endian = big;
      req_valid = 1'b1; req_write = wr; req_wdata = d; req_be = be;
      @(negedge clk);
      // R9: flip configuration and scramble request after acceptance
      req_valid = 1'b0; cfg_narrow = !narrow; cfg_big_endian = !big;
      req_wdata = ~d; req_be = ~be;
      check_beat(narrow, wr, narrow ? big : 1'b0, d, be);
      ext_dq_in = narrow ? {32'hDEAD_BEEF, ra} : {ra, rb};
      @(negedge clk);
      if (narrow) begin
         check("R9 second beat kept", {63'd0, ext_beat}, 64'd1);
         check_beat(1'b1, wr, !big, d, be);
         check("R7 no early response", {63'd0, rsp_valid}, 64'd0);
         ext_dq_in = {32'hBAD0_0BAD, rb};
         @(negedge clk);
      end
      check(narrow ? "R2 two beats only" : "R1 one beat only", {63'd0, ext_beat}, 64'd0);
      check("R7 response pulse", {63'd0, rsp_valid}, 64'd1);
      check("R4 idle masks", {56'd0, ext_dm}, 64'hFF);
      if (!wr) begin
         if (!narrow)  exp_rd = {ra, rb};
         else if (big) exp_rd = {ra, rb};
         else          exp_rd = {rb, ra};
         check("R6 read assembly", rsp_rdata, exp_rd);
      end
      cfg_narrow = narrow; cfg_big_endian = big;
      @(negedge clk);
      check("R7 single pulse", {63'd0, rsp_valid}, 64'd0);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [7:0] be_set [6];
      be_set = '{8'hFF, 8'h0F, 8'hF0, 8'h00, 8'h81, 8'h3C};
      rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; req_be = '0;
      cfg_narrow = 1'b0; cfg_big_endian = 1'b0; ext_dq_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      check("R10 ready", {63'd0, req_ready}, 64'd1);
      check("R10 beat", {63'd0, ext_beat}, 64'd0);
      check("R10 oe", {62'd0, ext_dq_oe_hi, ext_dq_oe_lo}, 64'd0);
      check("R10 masks", {56'd0, ext_dm}, 64'hFF);
      check("R10 rsp", {63'd0, rsp_valid}, 64'd0);
      for (int n = 0; n < 2; n++)
         for (int b = 0; b < 2; b++)
            for (int w = 0; w < 2; w++)
               for (int e = 0; e < 6; e++)
                  for (int p = 0; p < 3; p++) begin
                     logic [31:0] hi_w, lo_w;
                     hi_w = 32'h1357_9BDF * (p + 1) + 32'(e * 16 + n * 4 + b * 2 + w);
                     lo_w = 32'h2468_ACE0 ^ (32'h0101_0101 * (p + 3)) ^ 32'(e);
                     xfer(n[0], b[0], w[0], {hi_w, lo_w}, be_set[e], ~lo_w, hi_w + 32'd7);
                  end
      // reset during a two-beat sequence returns to idle
      cfg_narrow = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_be = 8'hFF;
      @(negedge clk);
      req_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R10 mid-transfer reset beat", {63'd0, ext_beat}, 64'd0);
      check("R10 mid-transfer reset masks", {56'd0, ext_dm}, 64'hFF);
      check("R10 mid-transfer reset ready", {63'd0, req_ready}, 64'd1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule